// File: doc/BRIEF.md
# ADC Offset and Gain Correction

This block post-processes the 24-bit two's complement results that a decimation filter produces. It subtracts a programmable offset word from each sample, then multiplies the difference by a programmable gain word. The gain word is a fixed-point factor whose unity value is 400000h. The scaled value is saturated back into the 24-bit signed range. Samples arrive with a valid strobe and leave two cycles later with their own strobe. A new sample may be accepted on every clock cycle.

The offset and gain words are each split into three byte-wide configuration registers behind a simple synchronous write port with a combinational read. Byte writes first go into a shadow copy. The working word changes only when its most significant byte is written, so a sample never sees a half-written word. Each sample is processed with the words that are in effect in the cycle the sample is accepted.

Top module: `adc_trim_path`

## Requirements
- R1: For each accepted sample x, with working offset o and gain g, out_data equals floor((x − o) · g / 2^22) after saturation to 24 bits. x and o are read as signed, and g as unsigned.
- R2: The subtraction x − o is formed at 25-bit signed width and never wraps. For example, x = 7FFFFFh, o = 800000h and g = 200000h give 7FFFFFh.
- R3: A scaled value above 8388607 is output as 7FFFFFh, and one below −8388608 is output as 800000h.
- R4: The scaling rounds toward negative infinity. With o = 0 and g = 200000h, input FFFFFFh gives FFFFFFh, 000001h gives 000000h and FFFFFDh gives FFFFFEh.
- R5: After reset the offset word is 000000h, the gain word is 400000h, out_valid is 0 and out_data is 000000h.
- R6: With input 0 and unity gain, the output is the negated offset. Offset 7FFFFFh gives 800001h, 000001h gives FFFFFFh, 000000h gives 000000h, FFFFFFh gives 000001h and 800001h gives 7FFFFFh.
- R7: Gain 800000h doubles the offset-corrected value, 200000h halves it, 400000h leaves it unchanged and 000000h forces the output to 0.
- R8: out_valid is asserted exactly two clock cycles after in_valid, and never otherwise. Samples on consecutive cycles produce outputs on consecutive cycles, in order.
- R9: The register addresses are as follows. Offset bits 7:0, 15:8 and 23:16 are at addresses 0, 1 and 2. Gain bits 7:0, 15:8 and 23:16 are at addresses 3, 4 and 5. A read returns the shadow byte. Addresses 6 and 7 read as 00h, and writes to them have no effect.
- R10: Writing the low or middle byte of a word does not change the word used for samples. Writing its high byte (address 2 or 5) loads all three shadow bytes into the working word at that clock edge.
- R11: While out_valid is 0, out_data keeps its last value.
- R12: A sample uses the offset and gain words in effect in its input cycle. A high-byte write in that same cycle affects only later samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Byte write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Write data byte |
| cfg_rdata | output | 8 | Shadow byte at cfg_addr (combinational) |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Filter result, two's complement |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | 24 | Corrected, saturated sample |

## Verification
The assertions assume that in_valid, in_data and the configuration inputs are always at known levels after reset. They also assume that reset is held for at least one rising edge, so that the output register starts from zero. The identity and zero-gain properties read the working words inside the block in the input cycle. They therefore rely on the two-stage pipeline capturing the gain word together with the difference. The bench drives every input on the falling edge, holds reset for several cycles, and never leaves a strobe or data bus undriven. This keeps the stimulus inside those assumptions, including the cycle where a high-byte write and a sample coincide.

// File: rtl/adc_trim_pkg.sv
package adc_trim_pkg;

    // Default geometry of the correction path
    localparam int unsigned TRIM_DATA_W = 24;  // sample and word width
    localparam int unsigned TRIM_REG_W  = 8;   // configuration register width
    localparam int unsigned TRIM_FRAC_W = 22;  // fraction bits of the gain word

    // Which stored word a configuration address refers to
    typedef enum logic [1:0] {
        TRIM_SEL_OFFSET = 2'd0,
        TRIM_SEL_GAIN   = 2'd1,
        TRIM_SEL_NONE   = 2'd2
    } trim_sel_e;

endpackage

// File: rtl/trim_cfg_regs.sv
module trim_cfg_regs
    import adc_trim_pkg::*;
#(
    parameter int unsigned DATA_W = TRIM_DATA_W,
    parameter int unsigned REG_W  = TRIM_REG_W,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [DATA_W-1:0] off_word,
    output logic [DATA_W-1:0] gain_word
);

    localparam int unsigned NB = DATA_W / REG_W;
    localparam logic [DATA_W-1:0] GAIN_ONE = DATA_W'(1) << (DATA_W - 2);

    typedef struct packed {
        logic [NB-1:0][REG_W-1:0] off_sh;
        logic [NB-1:0][REG_W-1:0] gain_sh;
        logic [DATA_W-1:0]        off_w;
        logic [DATA_W-1:0]        gain_w;
    } cfg_state_t;

    function automatic cfg_state_t cfg_reset_value();
        cfg_state_t v;
        v.off_sh  = '0;
        v.gain_sh = GAIN_ONE;
        v.off_w   = '0;
        v.gain_w  = GAIN_ONE;
        return v;
    endfunction

    cfg_state_t st_d, st_q;

    logic [NB-1:0] off_sel, gain_sel;
    logic [NB-1:0] off_hit, gain_hit;
    trim_sel_e     word_sel;

    // One decode lane per byte of each word
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign off_sel[i]  = (addr == ADDR_W'(i));
        assign gain_sel[i] = (addr == ADDR_W'(NB + i));
        assign off_hit[i]  = wr_en & off_sel[i];
        assign gain_hit[i] = wr_en & gain_sel[i];
    end

    always_comb begin
        if (|off_sel)       word_sel = TRIM_SEL_OFFSET;
        else if (|gain_sel) word_sel = TRIM_SEL_GAIN;
        else                word_sel = TRIM_SEL_NONE;
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NB; i++) begin
            if (off_hit[i])  st_d.off_sh[i]  = wdata;
            if (gain_hit[i]) st_d.gain_sh[i] = wdata;
        end
        // Commit only when the most significant byte is written
        if (off_hit[NB-1])  st_d.off_w  = st_d.off_sh;
        if (gain_hit[NB-1]) st_d.gain_w = st_d.gain_sh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= cfg_reset_value();
        else        st_q <= st_d;
    end

    // Combinational read of the shadow copy
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (word_sel == TRIM_SEL_OFFSET && off_sel[i]) rdata = st_q.off_sh[i];
            if (word_sel == TRIM_SEL_GAIN && gain_sel[i])  rdata = st_q.gain_sh[i];
        end
    end

    assign off_word  = st_q.off_w;
    assign gain_word = st_q.gain_w;

endmodule

// File: rtl/trim_offset_stage.sv
module trim_offset_stage
    import adc_trim_pkg::*;
#(
    parameter int unsigned DATA_W = TRIM_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [DATA_W-1:0]        off_word,
    input  logic [DATA_W-1:0]        gain_word,
    output logic                     s1_valid,
    output logic signed [DATA_W:0]   s1_diff,
    output logic [DATA_W-1:0]        s1_gain
);

    localparam int unsigned DIFF_W = DATA_W + 1;

    typedef struct packed {
        logic                     vld;
        logic signed [DIFF_W-1:0] diff;
        logic [DATA_W-1:0]        gain;
    } s1_state_t;

    s1_state_t st_d, st_q;

    logic signed [DIFF_W-1:0] x_ext, o_ext;

    // Sign-extend both operands by one bit so the difference cannot wrap
    assign x_ext = $signed({in_data[DATA_W-1], in_data});
    assign o_ext = $signed({off_word[DATA_W-1], off_word});

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.diff = x_ext - o_ext;
            st_d.gain = gain_word;  // gain travels with its sample
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_valid = st_q.vld;
    assign s1_diff  = st_q.diff;
    assign s1_gain  = st_q.gain;

endmodule

// File: rtl/trim_gain_stage.sv
module trim_gain_stage
    import adc_trim_pkg::*;
#(
    parameter int unsigned DATA_W = TRIM_DATA_W,
    parameter int unsigned FRAC_W = TRIM_FRAC_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   s1_valid,
    input  logic signed [DATA_W:0] s1_diff,
    input  logic [DATA_W-1:0]      s1_gain,
    output logic                   out_valid,
    output logic [DATA_W-1:0]      out_data
);

    localparam int unsigned DIFF_W = DATA_W + 1;
    localparam int unsigned PROD_W = DIFF_W + DATA_W + 1;
    localparam int unsigned HEAD_W = PROD_W - DATA_W + 1;

    localparam logic signed [PROD_W-1:0] POS_LIM =
        $signed({{HEAD_W{1'b0}}, {(DATA_W-1){1'b1}}});
    localparam logic signed [PROD_W-1:0] NEG_LIM =
        $signed({{HEAD_W{1'b1}}, {(DATA_W-1){1'b0}}});

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } s2_state_t;

    s2_state_t st_d, st_q;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic [DATA_W-1:0]        clipped;

    // Gain word is unsigned: zero-extend it before the signed multiply
    assign prod   = PROD_W'(s1_diff) * PROD_W'($signed({1'b0, s1_gain}));
    // Arithmetic shift floors toward negative infinity
    assign scaled = prod >>> FRAC_W;

    always_comb begin
        if (scaled > POS_LIM)      clipped = POS_LIM[DATA_W-1:0];
        else if (scaled < NEG_LIM) clipped = NEG_LIM[DATA_W-1:0];
        else                       clipped = scaled[DATA_W-1:0];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = s1_valid;
        if (s1_valid) st_d.data = clipped;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

endmodule

// File: rtl/adc_trim_path.sv
module adc_trim_path
    import adc_trim_pkg::*;
#(
    parameter int unsigned DATA_W = TRIM_DATA_W,
    parameter int unsigned REG_W  = TRIM_REG_W,
    parameter int unsigned FRAC_W = TRIM_FRAC_W,
    localparam int unsigned ADDR_W = $clog2(2 * (DATA_W / REG_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [DATA_W-1:0]      off_word;
    logic [DATA_W-1:0]      gain_word;
    logic                   s1_valid;
    logic signed [DATA_W:0] s1_diff;
    logic [DATA_W-1:0]      s1_gain;

    trim_cfg_regs #(
        .DATA_W (DATA_W),
        .REG_W  (REG_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .off_word  (off_word),
        .gain_word (gain_word)
    );

    trim_offset_stage #(
        .DATA_W (DATA_W)
    ) u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .off_word  (off_word),
        .gain_word (gain_word),
        .s1_valid  (s1_valid),
        .s1_diff   (s1_diff),
        .s1_gain   (s1_gain)
    );

    trim_gain_stage #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W)
    ) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_diff   (s1_diff),
        .s1_gain   (s1_gain),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/adc_trim_path_checker.sv
module adc_trim_path_checker #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned REG_W  = 8,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [DATA_W-1:0] off_word,
    input logic [DATA_W-1:0] gain_word
);

    localparam int unsigned NB = DATA_W / REG_W;
    localparam logic [ADDR_W-1:0] OFF_TOP  = ADDR_W'(NB - 1);
    localparam logic [ADDR_W-1:0] GAIN_TOP = ADDR_W'(2 * NB - 1);
    localparam logic [DATA_W-1:0] UNITY    = DATA_W'(1) << (DATA_W - 2);

    // R8: every accepted sample emerges two cycles later
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R8: no output strobe without an input two cycles earlier
    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R11: output data holds while idle
    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R10: low and middle byte writes leave the working words alone
    assert_partial_write_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr != OFF_TOP && cfg_addr != GAIN_TOP)
        |=> ($stable(off_word) && $stable(gain_word)));

    // R7: zero gain in the input cycle forces a zero output
    assert_zero_gain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && gain_word == '0) |=> ##1 (out_data == '0));

    // R1: zero offset and unity gain pass the sample through
    assert_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && off_word == '0 && gain_word == UNITY)
        |=> ##1 (out_data == $past(in_data, 2)));

endmodule

bind adc_trim_path adc_trim_path_checker #(
    .DATA_W (DATA_W),
    .REG_W  (REG_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .off_word  (off_word),
    .gain_word (gain_word)
);

// File: tb/adc_trim_path_test.sv
module adc_trim_path_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic        out_valid;
    logic [23:0] out_data;

    int checks = 0;
    int fails  = 0;

    // Bench-side model of the register file
    logic [7:0]  sh [0:5];
    logic [23:0] m_off  = 24'h000000;
    logic [23:0] m_gain = 24'h400000;

    adc_trim_path uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #2 clk = ~clk;  // 250 MHz

    function automatic logic [23:0] model(logic [23:0] x, logic [23:0] o, logic [23:0] g);
        longint d, p, q;
        d = longint'($signed(x)) - longint'($signed(o));
        p = d * longint'({40'd0, g});
        q = p >>> 22;
        if (q > 64'sd8388607)       return 24'h7FFFFF;
        else if (q < -64'sd8388608) return 24'h800000;
        else                        return q[23:0];
    endfunction

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a < 3'd6) sh[a] = d;
        if (a == 3'd2) m_off  = {sh[2], sh[1], sh[0]};
        if (a == 3'd5) m_gain = {sh[5], sh[4], sh[3]};
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_off(logic [23:0] v);
        wr(3'd0, v[7:0]); wr(3'd1, v[15:8]); wr(3'd2, v[23:16]);
    endtask

    task automatic set_gain(logic [23:0] v);
        wr(3'd3, v[7:0]); wr(3'd4, v[15:8]); wr(3'd5, v[23:16]);
    endtask

    task automatic rd(logic [2:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, {16'd0, cfg_rdata}, {16'd0, exp});
    endtask

    // One sample, checked two edges later against a given expectation
    task automatic sample(logic [23:0] x, logic [23:0] exp, string req);
        @(negedge clk);
        in_valid = 1'b1; in_data = x;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({req, " valid"}, {23'd0, out_valid}, 24'd1);
        chk(req, out_data, exp);
    endtask

    task automatic test_reset();
        chk("R5 out_valid", {23'd0, out_valid}, 24'd0);
        chk("R5 out_data", out_data, 24'h000000);
        rd(3'd0, 8'h00, "R5 off byte0");
        rd(3'd1, 8'h00, "R5 off byte1");
        rd(3'd2, 8'h00, "R5 off byte2");
        rd(3'd3, 8'h00, "R5 gain byte0");
        rd(3'd4, 8'h00, "R5 gain byte1");
        rd(3'd5, 8'h40, "R5 gain byte2");
        rd(3'd6, 8'h00, "R9 unmapped 6");
        rd(3'd7, 8'h00, "R9 unmapped 7");
        sample(24'h123456, 24'h123456, "R5 default passthrough");
    endtask

    task automatic test_negation();
        set_gain(24'h400000);
        set_off(24'h7FFFFF); sample(24'h0, 24'h800001, "R6 off 7FFFFF");
        set_off(24'h000001); sample(24'h0, 24'hFFFFFF, "R6 off 000001");
        set_off(24'h000000); sample(24'h0, 24'h000000, "R6 off 000000");
        set_off(24'hFFFFFF); sample(24'h0, 24'h000001, "R6 off FFFFFF");
        set_off(24'h800001); sample(24'h0, 24'h7FFFFF, "R6 off 800001");
    endtask

    task automatic test_gains();
        set_off(24'h0);
        set_gain(24'h800000); sample(24'h100000, 24'h200000, "R7 gain 2.0");
        sample(24'hF00000, 24'hE00000, "R7 gain 2.0 negative");
        set_gain(24'h200000); sample(24'h100000, 24'h080000, "R7 gain 0.5");
        set_gain(24'h000000); sample(24'h100000, 24'h000000, "R7 gain 0");
        set_gain(24'h400000); sample(24'h100000, 24'h100000, "R7 gain 1.0");
    endtask

    task automatic test_saturate();
        set_off(24'h0); set_gain(24'h800000);
        sample(24'h500000, 24'h7FFFFF, "R3 positive clip");
        sample(24'hB00000, 24'h800000, "R3 negative clip");
    endtask

    task automatic test_nowrap();
        set_gain(24'h200000);
        set_off(24'h800000); sample(24'h7FFFFF, 24'h7FFFFF, "R2 wide positive diff");
        set_off(24'h7FFFFF); sample(24'h800000, 24'h800000, "R2 wide negative diff");
    endtask

    task automatic test_floor();
        set_off(24'h0); set_gain(24'h200000);
        sample(24'hFFFFFF, 24'hFFFFFF, "R4 minus one halved");
        sample(24'h000001, 24'h000000, "R4 plus one halved");
        sample(24'hFFFFFD, 24'hFFFFFE, "R4 minus three halved");
    endtask

    task automatic test_general();
        set_off(24'h001234); set_gain(24'h5A0000);
        sample(24'h345678, model(24'h345678, m_off, m_gain), "R1 mixed A");
        sample(24'hC00321, model(24'hC00321, m_off, m_gain), "R1 mixed B");
        set_off(24'hFF0000); set_gain(24'h1234AB);
        sample(24'h7ABCDE, model(24'h7ABCDE, m_off, m_gain), "R1 mixed C");
    endtask

    task automatic test_stream();
        set_off(24'h000010); set_gain(24'h400000);
        @(negedge clk); in_valid = 1'b1; in_data = 24'h000100;
        @(negedge clk); in_data = 24'h000200;
        chk("R8 not after one cycle", {23'd0, out_valid}, 24'd0);
        @(negedge clk); in_data = 24'h000300;
        chk("R8 stream first valid", {23'd0, out_valid}, 24'd1);
        chk("R8 stream first", out_data, 24'h0000F0);
        @(negedge clk); in_valid = 1'b0;
        chk("R8 stream second", out_data, 24'h0001F0);
        @(negedge clk);
        chk("R8 stream third valid", {23'd0, out_valid}, 24'd1);
        chk("R8 stream third", out_data, 24'h0002F0);
        @(negedge clk);
        chk("R8 stream ends", {23'd0, out_valid}, 24'd0);
        // R11: data holds while idle
        repeat (3) @(negedge clk);
        chk("R11 idle valid", {23'd0, out_valid}, 24'd0);
        chk("R11 idle hold", out_data, 24'h0002F0);
    endtask

    task automatic test_partial();
        set_off(24'h0); set_gain(24'h400000);
        wr(3'd0, 8'h10);
        sample(24'h000100, 24'h000100, "R10 low byte only");
        rd(3'd0, 8'h10, "R9 shadow low byte");
        wr(3'd1, 8'h00);
        sample(24'h000100, 24'h000100, "R10 middle byte only");
        wr(3'd2, 8'h00);
        sample(24'h000100, 24'h0000F0, "R10 high byte commits");
        wr(3'd7, 8'hFF);
        wr(3'd6, 8'hFF);
        rd(3'd0, 8'h10, "R9 unmapped write ignored byte0");
        rd(3'd5, 8'h40, "R9 unmapped write ignored byte5");
        sample(24'h000100, 24'h0000F0, "R9 unmapped write no effect");
    endtask

    task automatic test_capture();
        set_off(24'h0); set_gain(24'h400000);
        // sample and gain high-byte write in the same cycle
        @(negedge clk);
        in_valid = 1'b1; in_data = 24'h001000;
        cfg_wr_en = 1'b1; cfg_addr = 3'd5; cfg_wdata = 8'h80;
        sh[5] = 8'h80; m_gain = {sh[5], sh[4], sh[3]};
        @(negedge clk);
        in_valid = 1'b0; cfg_wr_en = 1'b0;
        @(negedge clk);
        chk("R12 same-cycle write uses old gain", out_data, 24'h001000);
        sample(24'h001000, 24'h002000, "R12 next sample uses new gain");
    endtask

    initial begin
        for (int i = 0; i < 6; i++) sh[i] = 8'h00;
        sh[5] = 8'h40;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_negation();
        test_gains();
        test_saturate();
        test_nowrap();
        test_floor();
        test_general();
        test_stream();
        test_partial();
        test_capture();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule